// File: doc/BRIEF.md
# Serial Flash Write-Protection and Status Unit

This block keeps the status byte of a serial flash device and decides whether each write request may go ahead. It holds four pieces of state: a write-enable latch, a busy flag, a sticky protect-enable bit and a two-bit protection level. A hardware protect pin acts on the decision together with the protect-enable bit and the latch.

The command decoder sits beside it and sends single-cycle strobes: enable-writes, status write (with its data byte), program start (with the target address), and a done strobe from the write-cycle timer. From these the unit produces three permit outputs. One is for blocks inside the protected range, one for blocks outside it, and one for the status register. It also produces a flag that tells whether the program address falls in the protected range, and the status byte for read-back.

Top module: `wp_guard`

## Requirements
- R1: After a synchronous reset, `status_o` is 0x00 and all three permit outputs are 0.
- R2: When the unit is idle, an `set_wen_i` strobe sets the write-enable latch. The latch reads as bit 1 of `status_o` from the next cycle.
- R3: With the latch set, `perm_unprot_o` is 1 and `perm_prot_o` is 0. `perm_sr_o` is 1 when bit 7 of the status byte (protect-enable) is 0 or when `wp_high_i` is 1. Otherwise it is 0.
- R4: While the latch is 0, all three permit outputs are 0.
- R5: An idle status write that is permitted loads `sr_data_i[3:2]` into the level field (status bits 3:2) and `sr_data_i[7]` into the protect-enable bit. It also sets busy (status bit 0) on the next cycle.
- R6: An idle program start with the latch set is accepted when `prog_addr_i` lies outside the protected range, and accepted means busy is set on the next cycle. It is rejected when the address lies inside the range.
- R7: Busy stays 1 until a `cycle_done_i` strobe. That strobe clears both busy and the latch on the next edge. A done strobe while idle has no effect.
- R8: A rejected status write or program start clears the latch. It leaves busy, the level field and protect-enable unchanged.
- R9: While busy, `set_wen_i`, `sr_wr_i` and `prog_start_i` are ignored.
- R10: While `wp_high_i` is 0, a protect-enable bit that is 1 stays 1.
- R11: When strobes arrive in the same cycle, a status write wins over a program start, and a program start wins over enable-writes.
- R12: `addr_prot_o` reflects the two most significant address bits A. Level 0 protects nothing. Level 1 protects A=3. Level 2 protects A>=2. Level 3 protects every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_high_i | input | 1 | Hardware protect pin level (0 = protect asserted) |
| set_wen_i | input | 1 | Enable-writes strobe |
| sr_wr_i | input | 1 | Status write strobe |
| sr_data_i | input | 8 | Status write data |
| prog_start_i | input | 1 | Program start strobe |
| prog_addr_i | input | ADDR_W | Program target address |
| cycle_done_i | input | 1 | Write-cycle timer done strobe |
| status_o | output | 8 | Status byte: bit0 busy, bit1 latch, bits3:2 level, bit7 protect-enable |
| perm_prot_o | output | 1 | Permit for blocks in the protected range |
| perm_unprot_o | output | 1 | Permit for blocks outside the protected range |
| perm_sr_o | output | 1 | Permit for the status register |
| addr_prot_o | output | 1 | Program address lies in the protected range |

## Verification
Some invariants are checked by assertions on every cycle. These are: no permit without the latch, the protected-block permit never asserted, protect-enable holding while the pin is low, busy holding until the done strobe, the done strobe clearing busy and the latch, and an accepted status write raising busy. Other behaviours can only be shown by the bench's directed scenarios. These are: the exact field values loaded by a status write, latch clearing on rejection, the strobe priority order, and the protected-range boundaries at each level.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    typedef struct packed {
        logic       wpen;
        logic [1:0] level;
        logic       wel;
        logic       busy;
    } guard_state_t;

    localparam int LEVEL_W = 2;

    function automatic logic [7:0] pack_status(guard_state_t s);
        return {s.wpen, 3'b000, s.level, s.wel, s.busy};
    endfunction

    function automatic logic in_range(logic [1:0] top2, logic [1:0] lvl);
        logic [2:0] sum;
        sum = {1'b0, top2} + {1'b0, lvl};
        return (lvl == 2'd3) || (lvl != 2'd0 && sum[2]);
    endfunction

endpackage

// File: rtl/wp_permit_decode.sv
module wp_permit_decode (
    input  logic wel_i,
    input  logic wpen_i,
    input  logic wp_high_i,
    output logic perm_prot_o,
    output logic perm_unprot_o,
    output logic perm_sr_o
);
    always_comb begin
        perm_prot_o   = 1'b0;
        perm_unprot_o = wel_i;
        perm_sr_o     = wel_i && (!wpen_i || wp_high_i);
    end
endmodule

// File: rtl/wp_range_cmp.sv
module wp_range_cmp
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [LEVEL_W-1:0] level_i,
    output logic               hit_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        hit_o = in_range(addr_i[TOP -: 2], level_i);
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_high_i,
    input  logic              set_wen_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_data_i,
    input  logic              prog_start_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              perm_prot_o,
    output logic              perm_unprot_o,
    output logic              perm_sr_o,
    output logic              addr_prot_o
);
    guard_state_t st;
    logic         prog_ok;

    wp_permit_decode u_dec (
        .wel_i        (st.wel),
        .wpen_i       (st.wpen),
        .wp_high_i    (wp_high_i),
        .perm_prot_o  (perm_prot_o),
        .perm_unprot_o(perm_unprot_o),
        .perm_sr_o    (perm_sr_o)
    );

    wp_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr_i (prog_addr_i),
        .level_i(st.level),
        .hit_o  (addr_prot_o)
    );

    assign prog_ok  = addr_prot_o ? perm_prot_o : perm_unprot_o;
    assign status_o = pack_status(st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (st.busy) begin
            if (cycle_done_i) begin
                st.busy <= 1'b0;
                st.wel  <= 1'b0;
            end
        end else if (sr_wr_i) begin
            if (perm_sr_o) begin
                st.level <= sr_data_i[3:2];
                st.wpen  <= sr_data_i[7];
                st.busy  <= 1'b1;
            end else begin
                st.wel <= 1'b0;
            end
        end else if (prog_start_i) begin
            if (prog_ok) st.busy <= 1'b1;
            else         st.wel  <= 1'b0;
        end else if (set_wen_i) begin
            st.wel <= 1'b1;
        end
    end

    // R4: no permit of any kind without the latch
    a_r4_no_perm_without_wel: assert property (@(posedge clk) disable iff (rst)
        !status_o[1] |-> !(perm_prot_o || perm_unprot_o || perm_sr_o));

    // R3: protected blocks are never writable
    a_r3_prot_locked: assert property (@(posedge clk) disable iff (rst)
        !perm_prot_o);

    // R10: protect-enable sticks while the pin is low
    a_r10_wpen_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && !wp_high_i) |=> status_o[7]);

    // R7 / R9: busy holds until the done strobe
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && !cycle_done_i) |=> status_o[0]);

    // R7: done strobe ends the cycle and clears the latch
    a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && cycle_done_i) |=> (!status_o[0] && !status_o[1]));

    // R5: an accepted status write starts a cycle
    a_r5_sr_starts_busy: assert property (@(posedge clk) disable iff (rst)
        (!status_o[0] && sr_wr_i && perm_sr_o) |=> status_o[0]);

endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb_top;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_high = 1'b1;
    logic          set_wen = 1'b0, sr_wr = 1'b0, prog_start = 1'b0, done = 1'b0;
    logic [7:0]    sr_data = '0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    status;
    logic          p_prot, p_unprot, p_sr, a_prot;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wp_guard #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .wp_high_i(wp_high),
        .set_wen_i(set_wen), .sr_wr_i(sr_wr), .sr_data_i(sr_data),
        .prog_start_i(prog_start), .prog_addr_i(addr), .cycle_done_i(done),
        .status_o(status), .perm_prot_o(p_prot), .perm_unprot_o(p_unprot),
        .perm_sr_o(p_sr), .addr_prot_o(a_prot)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive strobes for one rising edge, then sample after it.
    task automatic step(logic w, logic s, logic p, logic d);
        set_wen = w; sr_wr = s; prog_start = p; done = d;
        @(negedge clk);
        set_wen = 0; sr_wr = 0; prog_start = 0; done = 0;
    endtask

    task automatic sr_set(logic [7:0] v);
        wp_high = 1'b1;
        step(1, 0, 0, 0);
        sr_data = v;
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);
    endtask

    task automatic t_reset;
        chk("R1 status", status, 8'h00);
        chk("R1 perms", {5'b0, p_prot, p_unprot, p_sr}, 8'h00);
        chk("R4 perms no wel", {5'b0, p_prot, p_unprot, p_sr}, 8'h00);
    endtask

    task automatic t_enable_and_write;
        step(1, 0, 0, 0);
        chk("R2 wel set", status, 8'h02);
        chk("R3 perms pin high", {5'b0, p_prot, p_unprot, p_sr}, 8'h03);
        sr_data = 8'h8C;
        step(0, 1, 0, 0);
        chk("R5 fields and busy", status, 8'h8F);
        step(0, 0, 0, 1);
        chk("R7 done clears", status, 8'h8C);
        step(0, 0, 0, 1);
        chk("R7 idle done ignored", status, 8'h8C);
    endtask

    task automatic t_pin_lock;
        wp_high = 1'b0;
        step(1, 0, 0, 0);
        chk("R3 sr locked", {5'b0, p_prot, p_unprot, p_sr}, 8'h02);
        sr_data = 8'h00;
        step(0, 1, 0, 0);
        chk("R8 R10 rejected sr write", status, 8'h8C);
        wp_high = 1'b1;
        step(1, 0, 0, 0);
        chk("R3 pin high unlocks", {5'b0, p_prot, p_unprot, p_sr}, 8'h03);
        step(0, 0, 0, 0);
        sr_data = 8'h04;
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);
        chk("R5 wpen cleared pin high", status, 8'h04);
    endtask

    task automatic t_program;
        addr = 19'h60000;
        #1 chk("R12 lvl1 top", {7'b0, a_prot}, 8'h01);
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        chk("R6 R8 protected rejected", status, 8'h04);
        addr = 19'h5FFFF;
        #1 chk("R12 lvl1 below", {7'b0, a_prot}, 8'h00);
        step(0, 0, 1, 0);
        chk("R8 no wel rejected", status, 8'h04);
        step(1, 0, 0, 0);
        addr = 19'h10000;
        step(0, 0, 1, 0);
        chk("R6 accepted busy", status, 8'h07);
        sr_data = 8'h0C;
        step(1, 1, 1, 0);
        chk("R9 ignored while busy", status, 8'h07);
        step(0, 0, 0, 1);
        chk("R7 done after program", status, 8'h04);
    endtask

    task automatic t_levels;
        sr_set(8'h08);
        addr = 19'h40000;
        #1 chk("R12 lvl2 hit", {7'b0, a_prot}, 8'h01);
        addr = 19'h3FFFF;
        #1 chk("R12 lvl2 miss", {7'b0, a_prot}, 8'h00);
        sr_set(8'h0C);
        addr = 19'h00000;
        #1 chk("R12 lvl3 all", {7'b0, a_prot}, 8'h01);
        sr_set(8'h00);
        addr = 19'h7FFFF;
        #1 chk("R12 lvl0 none", {7'b0, a_prot}, 8'h00);
    endtask

    task automatic t_priority;
        step(1, 0, 0, 0);
        sr_data = 8'h04;
        addr = 19'h00000;
        step(0, 1, 1, 0);
        chk("R11 sr over program", status, 8'h07);
        step(0, 0, 0, 1);
        step(1, 0, 1, 0);
        chk("R11 program over enable", status, 8'h04);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable_and_write();
        t_pin_lock();
        t_program();
        t_levels();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule